// File: doc/BRIEF.md
# Four-Way Junction Signal Controller

This block runs the signal heads of a four-road crossing. The roads are served one at a time in a fixed rotation. Each service period starts with a green interval. A two-part amber interval follows. In the second amber half the pedestrian-walk output for that road is on. Time is kept by a down-counter that steps only on a one-second enable pulse. Its value is brought out so that a display can show it.

A peak-traffic input selects the long green length when a green interval is loaded. Each road has a siren-detector input. While any siren is active, the controller stops its rotation and countdown. The road that requests service shows green and every other road shows red. When the siren clears, the rotation continues from the same road, interval and remaining count.

Top module: `junction_signal_ctrl`

## Requirements
- R1: While `rst` is high, every road shows red only and all walk outputs are low. On the first cycle after release, North (road code 0, bit 0 of every lamp vector) is green, and `secs_left` equals the green length chosen by `peak_mode` during reset.
- R2: Roads are served in code order: North 0, East 1, South 2, West 3. After West, service returns to North. Bit i of each lamp vector belongs to road code i.
- R3: `secs_left` falls by one only on a cycle with `sec_tick` high. An interval of length L shows L down to 1. Green lasts 60 ticks, or 120 ticks when peak is selected. Each amber half lasts 3 ticks (parameter `AMBER_HALF`).
- R4: `peak_mode` is sampled only when a green interval is loaded. Changing it part way through an interval does not alter the running count.
- R5: Outside preemption, exactly the served road is non-red. It shows green in the green interval and amber in either amber half. All other roads show red.
- R6: The walk output of the served road is high only in the second amber half. It is low in green and in the first amber half.
- R7: While any `siren` bit is high, the selected road shows green, all others show red, no amber is lit and all walk outputs are low.
- R8: While any `siren` bit is high, ticks have no effect. On release, the same road, interval and `secs_left` value reappear. Counting then continues from there.
- R9: When several sirens are active, the lowest road code wins (North, then East, South, West).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-second count enable, one cycle wide |
| peak_mode | input | 1 | Selects the long green length at the next green load |
| siren | input | 4 | Emergency request per road, bit = road code |
| lamp_red | output | 4 | Red lamp per road |
| lamp_amber | output | 4 | Amber lamp per road |
| lamp_green | output | 4 | Green lamp per road |
| walk_en | output | 4 | Pedestrian walk per road |
| secs_left | output | CNT_W (7) | Remaining seconds of the current interval |

## Verification
Some properties are checked on every cycle by the assertions:
- the road code only ever steps by one into a fresh green;
- the counter stays within its legal range;
- an active siren freezes road, interval and count;
- exactly one road is open;
- walk appears only under amber;
- a preempted junction shows only the granted green.

The exact interval lengths, the peak sampling instant, the full North-to-West rotation with its wrap, the priority among simultaneous sirens, and the exact resumed state after a siren clears depend on counted sequences. Only the bench's directed scenarios can show these.

// File: rtl/jsc_pkg.sv
package jsc_pkg;
   localparam int ROADS = 4;
   typedef logic [1:0] road_t;
   // bit0 = amber lit, bit1 = second amber half
   typedef enum logic [1:0] {
      PH_GO       = 2'b00,
      PH_AMBER_A  = 2'b01,
      PH_AMBER_B  = 2'b11
   } phase_t;
endpackage

// File: rtl/jsc_phase_timer.sv
module jsc_phase_timer
   import jsc_pkg::*;
#(
   parameter int GREEN_NORMAL = 60,
   parameter int GREEN_PEAK   = 120,
   parameter int AMBER_HALF   = 3,
   parameter int CNT_W        = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             hold,
   input  logic             peak,
   output road_t            road,
   output phase_t           phase,
   output logic [CNT_W-1:0] remain
);
   localparam logic [CNT_W-1:0] LEN_NORMAL = CNT_W'(GREEN_NORMAL);
   localparam logic [CNT_W-1:0] LEN_PEAK   = CNT_W'(GREEN_PEAK);
   localparam logic [CNT_W-1:0] LEN_AMBER  = CNT_W'(AMBER_HALF);
   localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);
   localparam int LONGEST = (GREEN_PEAK > GREEN_NORMAL) ?
                            ((GREEN_PEAK > AMBER_HALF) ? GREEN_PEAK : AMBER_HALF) :
                            ((GREEN_NORMAL > AMBER_HALF) ? GREEN_NORMAL : AMBER_HALF);

   logic [CNT_W-1:0] green_len;
   logic             advance;
   logic             live_q;

   assign green_len = peak ? LEN_PEAK : LEN_NORMAL;
   assign advance   = tick && !hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         road   <= '0;
         phase  <= PH_GO;
         remain <= green_len;
      end else if (advance) begin
         if (remain > ONE) begin
            remain <= remain - ONE;
         end else begin
            unique case (phase)
               PH_GO: begin
                  phase  <= PH_AMBER_A;
                  remain <= LEN_AMBER;
               end
               PH_AMBER_A: begin
                  phase  <= PH_AMBER_B;
                  remain <= LEN_AMBER;
               end
               default: begin
                  phase  <= PH_GO;
                  road   <= road + road_t'(1);
                  remain <= green_len;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) live_q <= 1'b0;
      else     live_q <= 1'b1;
   end

   AST_ROAD_STEP: assert property (@(posedge clk) disable iff (rst)
      (live_q && road != $past(road)) |-> (road == $past(road) + road_t'(1) && phase == PH_GO)); // R2
   AST_REMAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
      live_q |-> (remain >= ONE && int'(remain) <= LONGEST)); // R3
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
      hold |=> ($stable(remain) && $stable(road) && $stable(phase))); // R8
   AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(remain)); // R3
endmodule

// File: rtl/jsc_preempt_arb.sv
module jsc_preempt_arb #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_slot
      assign seen[i+1] = seen[i] | req[i];
      assign grant[i]  = req[i] & ~seen[i];
   end

   assign any = seen[N];

   always_comb begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant) && ((grant != '0) == (req != '0))); // R9
   end
endmodule

// File: rtl/jsc_lamp_decode.sv
module jsc_lamp_decode
   import jsc_pkg::*;
#(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  road_t        road,
   input  phase_t       phase,
   input  logic         preempt,
   input  logic [N-1:0] grant,
   output logic [N-1:0] red,
   output logic [N-1:0] amber,
   output logic [N-1:0] green,
   output logic [N-1:0] walk
);
   for (genvar i = 0; i < N; i++) begin : g_head
      logic served;
      assign served = (road == road_t'(i));
      always_comb begin
         if (rst) begin
            red[i]   = 1'b1;
            amber[i] = 1'b0;
            green[i] = 1'b0;
            walk[i]  = 1'b0;
         end else if (preempt) begin
            green[i] = grant[i];
            red[i]   = ~grant[i];
            amber[i] = 1'b0;
            walk[i]  = 1'b0;
         end else begin
            green[i] = served && phase == PH_GO;
            amber[i] = served && phase[0];
            red[i]   = ~served;
            walk[i]  = served && phase == PH_AMBER_B;
         end
      end
   end

   AST_ONE_OPEN: assert property (@(posedge clk) disable iff (rst)
      $countones(~red) == 1 && ((green | amber) == ~red)); // R5
   AST_WALK_IN_AMBER: assert property (@(posedge clk) disable iff (rst)
      (walk & ~amber) == '0); // R6
   AST_RESET_RED: assert property (@(posedge clk)
      rst |-> (red == '1 && walk == '0 && green == '0)); // R1
endmodule

// File: rtl/junction_signal_ctrl.sv
module junction_signal_ctrl
   import jsc_pkg::*;
#(
   parameter int GREEN_NORMAL = 60,
   parameter int GREEN_PEAK   = 120,
   parameter int AMBER_HALF   = 3,
   localparam int LONGEST = (GREEN_PEAK > GREEN_NORMAL) ?
                            ((GREEN_PEAK > AMBER_HALF) ? GREEN_PEAK : AMBER_HALF) :
                            ((GREEN_NORMAL > AMBER_HALF) ? GREEN_NORMAL : AMBER_HALF),
   localparam int CNT_W = $clog2(LONGEST + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sec_tick,
   input  logic             peak_mode,
   input  logic [3:0]       siren,
   output logic [3:0]       lamp_red,
   output logic [3:0]       lamp_amber,
   output logic [3:0]       lamp_green,
   output logic [3:0]       walk_en,
   output logic [CNT_W-1:0] secs_left
);
   if (GREEN_NORMAL < 1 || GREEN_PEAK < 1 || AMBER_HALF < 1) begin : g_bad_len
      $error("junction_signal_ctrl: every interval length must be at least 1");
   end
   if (ROADS != 4) begin : g_bad_roads
      $error("junction_signal_ctrl: road code is two bits, four roads required");
   end

   road_t      road;
   phase_t     phase;
   logic [3:0] grant;
   logic       preempt;

   jsc_preempt_arb #(.N(ROADS)) u_arb (
      .req   (siren),
      .grant (grant),
      .any   (preempt)
   );

   jsc_phase_timer #(
      .GREEN_NORMAL (GREEN_NORMAL),
      .GREEN_PEAK   (GREEN_PEAK),
      .AMBER_HALF   (AMBER_HALF),
      .CNT_W        (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .tick   (sec_tick),
      .hold   (preempt),
      .peak   (peak_mode),
      .road   (road),
      .phase  (phase),
      .remain (secs_left)
   );

   jsc_lamp_decode #(.N(ROADS)) u_lamps (
      .clk     (clk),
      .rst     (rst),
      .road    (road),
      .phase   (phase),
      .preempt (preempt),
      .grant   (grant),
      .red     (lamp_red),
      .amber   (lamp_amber),
      .green   (lamp_green),
      .walk    (walk_en)
   );

   AST_PREEMPT_LAMPS: assert property (@(posedge clk) disable iff (rst)
      (siren != 4'b0) |-> (walk_en == 4'b0 && lamp_amber == 4'b0 &&
                           $countones(lamp_green) == 1 && (lamp_green & siren) == lamp_green)); // R7
   AST_SIREN_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (siren != 4'b0) |=> $stable(secs_left)); // R8
endmodule

// File: tb/junction_signal_ctrl_tb.sv
module junction_signal_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sec_tick = 1'b0;
   logic       peak_mode = 1'b0;
   logic [3:0] siren = 4'b0;
   logic [3:0] lamp_red, lamp_amber, lamp_green, walk_en;
   logic [6:0] secs_left;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // requirement-level model of the service state
   int m_road = 0;
   int m_ph = 0;      // 0 green, 1 first amber half, 2 second amber half
   int m_rem = 60;

   always #5 clk = ~clk;

   junction_signal_ctrl u_dut (
      .clk(clk), .rst(rst), .sec_tick(sec_tick), .peak_mode(peak_mode),
      .siren(siren), .lamp_red(lamp_red), .lamp_amber(lamp_amber),
      .lamp_green(lamp_green), .walk_en(walk_en), .secs_left(secs_left)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_tick();
      if (m_rem > 1) m_rem--;
      else if (m_ph == 0) begin m_ph = 1; m_rem = 3; end
      else if (m_ph == 1) begin m_ph = 2; m_rem = 3; end
      else begin m_ph = 0; m_road = (m_road + 1) % 4; m_rem = peak_mode ? 120 : 60; end
   endtask

   task automatic cmp_all(input string tag);
      int g, a, r, w, sel;
      if (siren != 0) begin
         sel = 0;
         for (int i = 3; i >= 0; i--) if (siren[i]) sel = i;
         g = 1 << sel; a = 0; r = 15 & ~g; w = 0;
      end else begin
         g = (m_ph == 0) ? (1 << m_road) : 0;
         a = (m_ph != 0) ? (1 << m_road) : 0;
         r = 15 & ~(1 << m_road);
         w = (m_ph == 2) ? (1 << m_road) : 0;
      end
      chk(tag, "green", int'(lamp_green), g);
      chk(tag, "amber", int'(lamp_amber), a);
      chk(tag, "red",   int'(lamp_red), r);
      chk(tag, "walk",  int'(walk_en), w);
      chk(tag, "secs_left", int'(secs_left), m_rem);
   endtask

   task automatic pulse(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) sec_tick = 1'b1;
         @(negedge clk) sec_tick = 1'b0;
         if (siren == 4'b0) model_tick();
      end
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      chk("R1", "red in reset", int'(lamp_red), 15);
      chk("R1", "green in reset", int'(lamp_green), 0);
      chk("R1", "walk in reset", int'(walk_en), 0);
      rst = 1'b0;
      m_road = 0; m_ph = 0; m_rem = 60;
      @(negedge clk);
      chk("R1", "north green after release", int'(lamp_green), 1);
      chk("R1", "initial count", int'(secs_left), 60);
      cmp_all("R1");
   endtask

   task automatic t_rotation();
      for (int d = 0; d < 4; d++) begin
         chk("R2", "served road green", int'(lamp_green), 1 << d);
         chk("R3", "green length", int'(secs_left), 60);
         pulse(59);
         chk("R3", "last green second", int'(secs_left), 1);
         cmp_all("R5");
         pulse(1);
         chk("R6", "first amber no walk", int'(walk_en), 0);
         chk("R3", "amber half length", int'(secs_left), 3);
         cmp_all("R5");
         pulse(3);
         chk("R6", "second amber walk", int'(walk_en), 1 << d);
         cmp_all("R6");
         pulse(3);
      end
      chk("R2", "wrap to north", int'(lamp_green), 1);
      cmp_all("R2");
   endtask

   task automatic t_tick_gate();
      pulse(2);
      repeat (10) @(negedge clk);
      chk("R3", "no tick no count", int'(secs_left), 58);
      cmp_all("R3");
   endtask

   task automatic t_peak();
      // north green currently loaded at normal length, 58 left
      peak_mode = 1'b1;
      pulse(57);
      chk("R4", "mid-interval peak ignored", int'(secs_left), 1);
      pulse(7);
      chk("R3", "peak green length", int'(secs_left), 120);
      chk("R4", "east green", int'(lamp_green), 2);
      peak_mode = 1'b0;
      pulse(119);
      chk("R4", "peak green runs full", int'(secs_left), 1);
      pulse(7);
      chk("R4", "normal length back", int'(secs_left), 60);
      cmp_all("R4");
   endtask

   task automatic t_preempt();
      // south green, 60 left
      pulse(64);
      chk("R6", "second amber reached", int'(walk_en), 4);
      chk("R8", "count before siren", int'(secs_left), 2);
      @(negedge clk) siren = 4'b1000;
      @(negedge clk);
      chk("R7", "west green on siren", int'(lamp_green), 8);
      chk("R7", "others red", int'(lamp_red), 7);
      chk("R7", "walk off", int'(walk_en), 0);
      pulse(5);
      chk("R8", "frozen count", int'(secs_left), 2);
      cmp_all("R7");
      @(negedge clk) siren = 4'b0000;
      @(negedge clk);
      chk("R8", "walk resumes", int'(walk_en), 4);
      chk("R8", "amber resumes", int'(lamp_amber), 4);
      chk("R8", "count resumes", int'(secs_left), 2);
      pulse(2);
      chk("R8", "continues to west", int'(lamp_green), 8);
      cmp_all("R8");
   endtask

   task automatic t_priority();
      pulse(10);
      @(negedge clk) siren = 4'b1010;
      @(negedge clk);
      chk("R9", "east beats west", int'(lamp_green), 2);
      siren = 4'b1100;
      @(negedge clk);
      chk("R9", "south beats west", int'(lamp_green), 4);
      siren = 4'b1111;
      pulse(3);
      chk("R9", "north beats all", int'(lamp_green), 1);
      cmp_all("R9");
      siren = 4'b0000;
      @(negedge clk);
      chk("R8", "west green resumed", int'(lamp_green), 8);
      chk("R8", "count resumed", int'(secs_left), 50);
      cmp_all("R8");
   endtask

   initial begin
      t_reset();
      t_rotation();
      t_tick_gate();
      t_peak();
      t_preempt();
      t_priority();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule